// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a short circular history of where program flow changed. Each time the core signals that a change-of-flow instruction was executed, the block stores that instruction's address. If the flow change was taken, it also stores the destination address in the next slot. A conditional branch whose condition was false leaves a single source entry with a flag bit set. Recording is frozen while the core sits in debug mode, so the history shows the path that led into the halt.

A debugger reads the history through one register address. Each read strobe returns the entry under a read pointer and then moves the pointer on by one. When debug mode is entered, the read pointer is aimed at the oldest entry. Eight reads therefore walk the history from oldest to newest and leave the pointer where it started.

Top module: `cof_trace_buf`

## Requirements
- R1: After reset every entry reads as zero (address 0, flag clear), and both pointers start at slot 0.
- R2: A recorded change-of-flow with `taken_i` high writes two consecutive slots: the source address (`pc_i`) first, then the target address (`target_i`), both with the flag clear. The write pointer advances by two.
- R3: A recorded change-of-flow with `not_taken_i` high and `taken_i` low writes one slot holding `pc_i` with the flag set. The write pointer advances by one.
- R4: Read word layout: bit 0 is the not-taken flag and bits 16:1 hold the 16-bit address.
- R5: In the cycle `debug_i` rises, the read pointer is loaded from the write pointer, so the first read in debug mode returns the oldest entry.
- R6: Each read strobe advances the read pointer by one slot. Reads return entries from oldest to newest, and the ninth read returns the same entry as the first.
- R7: While `debug_i` is high, `cof_i` has no effect, and all entries and the write pointer keep their values.
- R8: The buffer is circular. After more than eight entries have been written, the newest eight are kept and the oldest are overwritten.
- R9: A recorded change-of-flow with neither indication writes one source entry with the flag clear. If both indications are high, `taken_i` wins.
- R10: A read strobe in the same cycle that `debug_i` rises is ignored. The load of the read pointer takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Address of the executed instruction |
| target_i | input | 16 | Destination address of a taken flow change |
| cof_i | input | 1 | A change-of-flow instruction executed this cycle |
| taken_i | input | 1 | The flow change was taken |
| not_taken_i | input | 1 | The conditional flow change was not taken |
| debug_i | input | 1 | Core is in debug mode |
| rd_i | input | 1 | Read strobe for the shared trace address |
| rd_data_o | output | 17 | Entry under the read pointer: {address, not-taken flag} |

## Verification
The bench builds the block with its default parameters: a 16-bit address and eight slots, which gives a 4-bit pointer. With these values, ten entries written between two debug sessions are enough to wrap the write index past slot 7. The same run also overflows the wide pointer, and nine-read sweeps show the read index closing its loop. The small depth also means a full history fits in one read sweep. This makes it practical to check every slot after a taken pair, a not-taken branch, an unflagged source, recording attempts made during debug, and a read strobe that coincides with debug entry.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_DEPTH  = 8;

  typedef enum logic [1:0] {
    REC_NONE = 2'd0,
    REC_SRC  = 2'd1,
    REC_PAIR = 2'd2
  } rec_kind_e;
endpackage

// File: rtl/cof_trace_wr_ctl.sv
module cof_trace_wr_ctl
  import cof_trace_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1,
  localparam int unsigned ENT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cof_i,
  input  logic              taken_i,
  input  logic              not_taken_i,
  input  logic              debug_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              we0_o,
  output logic [IDX_W-1:0]  idx0_o,
  output logic [ENT_W-1:0]  d0_o,
  output logic              we1_o,
  output logic [IDX_W-1:0]  idx1_o,
  output logic [ENT_W-1:0]  d1_o,
  output logic [PTR_W-1:0]  wr_ptr_o
);
  rec_kind_e        kind;
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] step;

  always_comb begin
    if (!cof_i || debug_i) kind = REC_NONE;
    else if (taken_i)      kind = REC_PAIR;
    else                   kind = REC_SRC;
  end

  always_comb begin
    unique case (kind)
      REC_PAIR: step = PTR_W'(2);
      REC_SRC:  step = PTR_W'(1);
      default:  step = '0;
    endcase
  end

  // source always lands in the slot under the write pointer, target right after
  assign we0_o  = (kind != REC_NONE);
  assign idx0_o = wr_ptr_q[IDX_W-1:0];
  assign d0_o   = {pc_i, (kind == REC_SRC) && not_taken_i};
  assign we1_o  = (kind == REC_PAIR);
  assign idx1_o = idx0_o + IDX_W'(1);
  assign d1_o   = {target_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + step;
  end

  assign wr_ptr_o = wr_ptr_q;
endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
  parameter int unsigned ENT_W = 17,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we0_i,
  input  logic [IDX_W-1:0] idx0_i,
  input  logic [ENT_W-1:0] d0_i,
  input  logic             we1_i,
  input  logic [IDX_W-1:0] idx1_i,
  input  logic [ENT_W-1:0] d1_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [ENT_W-1:0] rdata_o
);
  logic [ENT_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_q[g] <= '0;
      else if (we1_i && (idx1_i == IDX_W'(g)))    ent_q[g] <= d1_i;
      else if (we0_i && (idx0_i == IDX_W'(g)))    ent_q[g] <= d0_i;
    end
  end

  assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/cof_trace_rd_ctl.sv
module cof_trace_rd_ctl #(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             debug_i,
  input  logic             rd_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  output logic [PTR_W-1:0] rd_ptr_o
);
  logic             debug_q;
  logic             entry;
  logic [PTR_W-1:0] rd_ptr_q;

  assign entry = debug_i && !debug_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debug_q  <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      debug_q <= debug_i;
      // write pointer addresses the oldest slot; entry load beats a read
      if (entry)     rd_ptr_q <= wr_ptr_i;
      else if (rd_i) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
    end
  end

  assign rd_ptr_o = rd_ptr_q;
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
  import cof_trace_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              cof_i,
  input  logic              taken_i,
  input  logic              not_taken_i,
  input  logic              debug_i,
  input  logic              rd_i,
  output logic [ADDR_W:0]   rd_data_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned PTR_W = IDX_W + 1;
  localparam int unsigned ENT_W = ADDR_W + 1;

  logic             we0, we1;
  logic [IDX_W-1:0] idx0, idx1;
  logic [ENT_W-1:0] d0, d1;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  cof_trace_wr_ctl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wr (
    .clk_i, .rst_ni, .cof_i, .taken_i, .not_taken_i, .debug_i, .pc_i, .target_i,
    .we0_o(we0), .idx0_o(idx0), .d0_o(d0),
    .we1_o(we1), .idx1_o(idx1), .d1_o(d1),
    .wr_ptr_o(wr_ptr)
  );

  cof_trace_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .we0_i(we0), .idx0_i(idx0), .d0_i(d0),
    .we1_i(we1), .idx1_i(idx1), .d1_i(d1),
    .ridx_i(rd_ptr[IDX_W-1:0]), .rdata_o(rd_data_o)
  );

  cof_trace_rd_ctl #(.PTR_W(PTR_W)) u_rd (
    .clk_i, .rst_ni, .debug_i, .rd_i,
    .wr_ptr_i(wr_ptr), .rd_ptr_o(rd_ptr)
  );
endmodule

// File: rtl/cof_trace_buf_chk.sv
module cof_trace_buf_chk #(
  parameter int unsigned PTR_W = 4,
  parameter int unsigned ENT_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cof_i,
  input logic             taken_i,
  input logic             not_taken_i,
  input logic             debug_i,
  input logic             rd_i,
  input logic [ENT_W-1:0] rd_data_o,
  input logic [PTR_W-1:0] wr_ptr_i,
  input logic [PTR_W-1:0] rd_ptr_i
);
  assert_pair_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cof_i && taken_i && !debug_i) |=> (wr_ptr_i == PTR_W'($past(wr_ptr_i) + PTR_W'(2))));

  assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cof_i && !taken_i && !debug_i) |=> (wr_ptr_i == PTR_W'($past(wr_ptr_i) + PTR_W'(1))));

  assert_entry_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(debug_i) |=> (rd_ptr_i == $past(wr_ptr_i)));

  assert_read_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_i && $past(debug_i) && rd_i) |=> (rd_ptr_i == PTR_W'($past(rd_ptr_i) + PTR_W'(1))));

  assert_frozen_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_i && $past(debug_i) && !rd_i) |=> $stable(rd_data_o));

  assert_frozen_wptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_i |=> $stable(wr_ptr_i));
endmodule

bind cof_trace_buf cof_trace_buf_chk #(.PTR_W(PTR_W), .ENT_W(ENT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cof_i(cof_i), .taken_i(taken_i),
  .not_taken_i(not_taken_i), .debug_i(debug_i), .rd_i(rd_i),
  .rd_data_o(rd_data_o), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr)
);

// File: tb/cof_trace_buf_test.sv
module cof_trace_buf_test;
  localparam int AW = 16;
  localparam int N  = 8;

  typedef struct {
    logic [AW:0] data;
    string       req;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] pc_i = '0, target_i = '0;
  logic          cof_i = 1'b0, taken_i = 1'b0, not_taken_i = 1'b0;
  logic          debug_i = 1'b0, rd_i = 1'b0;
  logic [AW:0]   rd_data_o;

  int checks = 0, fails = 0;
  bit mon_en = 1'b0;
  item_t sb_q[$];
  logic [AW:0] exp_mem [N];
  int exp_wp = 0, exp_rp = 0;

  always #10 clk_i = ~clk_i;

  cof_trace_buf uut (.*);

  task automatic check(input bit ok, input string req, input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops the scoreboard on every enabled read strobe
  always @(negedge clk_i) begin
    if (rst_ni && rd_i && mon_en) begin
      if (sb_q.size() == 0) check(1'b0, "SB", rd_data_o, '0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(rd_data_o == it.data, it.req, rd_data_o, it.data);
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic rec(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit tk, input bit nt);
    pc_i = pc; target_i = tgt; cof_i = 1'b1; taken_i = tk; not_taken_i = nt;
    if (!debug_i) begin
      exp_mem[exp_wp % N] = {pc, nt && !tk};
      exp_wp++;
      if (tk) begin
        exp_mem[exp_wp % N] = {tgt, 1'b0};
        exp_wp++;
      end
    end
    step();
    cof_i = 1'b0; taken_i = 1'b0; not_taken_i = 1'b0;
  endtask

  task automatic enter_debug(input bit with_rd);
    debug_i = 1'b1;
    rd_i = with_rd;   // R10: strobe on entry cycle must be ignored
    mon_en = 1'b0;
    exp_rp = exp_wp;
    step();
    rd_i = 1'b0;
  endtask

  task automatic leave_debug();
    debug_i = 1'b0;
    step();
  endtask

  task automatic reads(input int n, input string first_req, input string rest_req);
    mon_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.data = exp_mem[exp_rp % N];
      it.req  = (k == 0) ? first_req : rest_req;
      sb_q.push_back(it);
      exp_rp++;
      rd_i = 1'b1;
      step();
    end
    rd_i = 1'b0;
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) exp_mem[i] = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    step();

    // R1 reset contents, R6 ninth read wraps to the first
    enter_debug(1'b0);
    reads(8, "R1", "R1");
    reads(1, "R6", "R6");
    leave_debug();

    // R2 taken pair, R3 not-taken, R9 neither / both
    rec(16'h1000, 16'h2000, 1'b1, 1'b0);
    rec(16'h1004, 16'h0000, 1'b0, 1'b1);
    rec(16'h1010, 16'h0000, 1'b0, 1'b0);
    rec(16'h1020, 16'h3000, 1'b1, 1'b1);
    enter_debug(1'b0);
    reads(1, "R5", "R5");
    reads(8, "R2", "R6");

    // R7 recording attempts during debug change nothing
    rec(16'hDEAD, 16'hBEEF, 1'b1, 1'b0);
    rec(16'hDEAD, 16'h0000, 1'b0, 1'b1);
    reads(8, "R7", "R7");
    leave_debug();

    // R8 ten more entries wrap the buffer
    for (int i = 0; i < 5; i++)
      rec(16'h4000 + 16'(i * 16), 16'h5000 + 16'(i * 16), 1'b1, 1'b0);
    enter_debug(1'b1);
    reads(1, "R10", "R10");
    reads(8, "R8", "R8");
    leave_debug();

    // R4 layout: newest entry is a not-taken branch at BEEF
    rec(16'hBEEF, 16'h0000, 1'b0, 1'b1);
    enter_debug(1'b0);
    reads(7, "R3", "R3");
    #3;
    check(rd_data_o[0] == 1'b1, "R4", {16'h0, rd_data_o[0]}, 17'h1);
    check(rd_data_o[AW:1] == 16'hBEEF, "R4", {1'b0, rd_data_o[AW:1]}, {1'b0, 16'hBEEF});
    leave_debug();

    step();
    check(sb_q.size() == 0, "SB", 17'(sb_q.size()), '0);
    finish_run();
  end
endmodule